// File: doc/BRIEF.md
# Converter start and status control register

This block is the small control register that sits between software and an analog-to-digital converter core. It decides which events may start a conversion, records whether a conversion is running, and raises an interrupt request when a conversion finishes. Software reaches it through a byte-wide register with a write strobe and an always-visible read value. Hardware can also start conversions through an external trigger pulse and a timer trigger pulse, each gated by a two-bit source selector.

The converter core answers with a one-cycle done pulse and may report a pause. The block emits a one-cycle start pulse and a one-cycle stop pulse toward the core. Software can also abort a running conversion through the register.

Register layout (one byte, read and write): bit 0 start command (write-only, reads 0), bit 1 busy, bit 2 completion flag, bit 3 interrupt enable, bits 5:4 source selector, bit 6 reserved (reads 0), bit 7 pause flag.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00 and `start_pulse`, `stop_pulse` and `irq` are 0.
- R2: The selector in bits 5:4 picks the hardware start sources: 00 none, 01 external trigger, 10 timer trigger, 11 both. An accepted start raises `start_pulse` for one cycle after the clock edge, and busy (bit 1) reads 1 from that edge.
- R3: A write with bit 0 set starts a conversion from idle unless `ext_mode` is high. Bit 0 always reads 0.
- R4: While busy is 1, trigger pulses and software starts are ignored and produce no `start_pulse`.
- R5: A `conv_done` pulse while busy clears busy and sets the completion flag (bit 2) at the next edge. A `conv_done` pulse while idle has no effect.
- R6: Writing 0 to bit 1 while busy gives a one-cycle `stop_pulse` and clears busy, and does not set the flag. Writing 1 to bit 1 has no effect.
- R7: Writing 0 to bit 2 clears the flag and writing 1 leaves it. A done pulse in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is 1 exactly when the flag and the interrupt enable (bit 3) are both 1.
- R9: A `pause_req` pulse sets bit 7. Writing 0 to bit 7 clears it. If both happen in one cycle, the bit stays set.
- R10: The reserved bit 6 always reads 0, whatever was written to it.
- R11: A trigger arriving in the same cycle as a write to the selector is judged by the selector value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| ext_trig | input | 1 | External start trigger pulse |
| tmr_trig | input | 1 | Timer start trigger pulse |
| ext_mode | input | 1 | Companion mode; high blocks software start |
| conv_done | input | 1 | Conversion-complete pulse from the core |
| pause_req | input | 1 | Pause report from the core |
| start_pulse | output | 1 | One-cycle conversion start |
| stop_pulse | output | 1 | One-cycle conversion abort |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. A completion pulse can meet a software write that clears the flag, and a trigger pulse can meet a write that changes the selector. The bench drives each pair on the same clock edge. It expects the flag to stay set in the first case. In the second it expects a start only when the old selector admitted that trigger, and it checks both directions of the selector change. The same set-wins rule is checked for a pause report that coincides with a pause-clearing write.

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_trig,
  input  logic       tmr_trig,
  input  logic       ext_mode,
  input  logic       conv_done,
  input  logic       pause_req,
  output logic       start_pulse,
  output logic       stop_pulse,
  output logic       irq
);

  logic       busy_q, flag_q, ie_q, pause_q, start_q, stop_q;
  logic [1:0] sel_q;

  wire sw_go  = wr_en && wr_data[0] && !ext_mode;
  wire hw_go  = (ext_trig && sel_q[0]) || (tmr_trig && sel_q[1]);
  wire go     = !busy_q && (sw_go || hw_go);
  wire abort  = busy_q && wr_en && !wr_data[1];
  wire finish = busy_q && conv_done && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      pause_q <= 1'b0;
      sel_q   <= 2'b00;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= go;
      stop_q  <= abort;
      if (go) busy_q <= 1'b1;
      else if (abort || finish) busy_q <= 1'b0;
      if (finish) flag_q <= 1'b1;
      else if (wr_en && !wr_data[2]) flag_q <= 1'b0;
      if (pause_req) pause_q <= 1'b1;
      else if (wr_en && !wr_data[7]) pause_q <= 1'b0;
      if (wr_en) begin
        ie_q  <= wr_data[3];
        sel_q <= wr_data[5:4];
      end
    end
  end

  assign rd_data     = {pause_q, 1'b0, sel_q, ie_q, flag_q, busy_q, 1'b0};
  assign start_pulse = start_q;
  assign stop_pulse  = stop_q;
  assign irq         = flag_q && ie_q;

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy_q);
  assert_busy_blocks_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !start_pulse);
  assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy_q && !(wr_en && !wr_data[1])) |=> (flag_q && !busy_q));
  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !busy_q);
  assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, stop_pulse}));
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[2] && !conv_done) |=> !flag_q);
  assert_pause_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> rd_data[7]);

endmodule

// File: tb/adc_start_ctrl_tb.sv
module adc_start_ctrl_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_trig = 0, tmr_trig = 0;
  logic ext_mode = 0, conv_done = 0, pause_req = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic start_pulse, stop_pulse, irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  adc_start_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ext_trig(ext_trig), .tmr_trig(tmr_trig), .ext_mode(ext_mode),
    .conv_done(conv_done), .pause_req(pause_req),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic [7:0] kv(input [1:0] s, input ie);
    return {1'b1, 1'b0, s, ie, 1'b1, 1'b1, 1'b0};
  endfunction

  task automatic wr(input [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic done_pulse();
    conv_done = 1;
    @(negedge clk);
    conv_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 pulses", {start_pulse, stop_pulse, irq}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int s = 0; s < 4; s++)
      for (int src = 0; src < 3; src++)
        for (int em = 0; em < 2; em++) begin
          logic e;
          wr(kv(s[1:0], 1'b0));
          ext_mode = em[0];
          if (src == 0) begin
            wr(kv(s[1:0], 1'b0) | 8'h01);
            e = !em[0];
          end else begin
            if (src == 1) ext_trig = 1; else tmr_trig = 1;
            @(negedge clk);
            ext_trig = 0; tmr_trig = 0;
            e = (src == 1) ? s[0] : s[1];
          end
          chk(src == 0 ? "R3 start" : "R2 start", start_pulse, e);
          chk("R2 busy", rd_data[1], e);
          chk("R3 start bit reads 0", rd_data[0], 0);
          ext_mode = 0;
          if (e) begin
            @(negedge clk);
            chk("R2 single pulse", start_pulse, 0);
            done_pulse();
            chk("R5 busy cleared", rd_data[1], 0);
            chk("R5 flag set", rd_data[2], 1);
            wr(kv(s[1:0], 1'b0) & ~8'h04);
            chk("R7 flag cleared", rd_data[2], 0);
          end
        end

    done_pulse();
    chk("R5 idle done ignored", rd_data[2:1], 0);

    wr(kv(2'b11, 1'b0) | 8'h01);
    chk("R4 started", rd_data[1], 1);
    @(negedge clk);
    ext_trig = 1; tmr_trig = 1;
    @(negedge clk);
    ext_trig = 0; tmr_trig = 0;
    chk("R4 trigger ignored", start_pulse, 0);
    wr(kv(2'b11, 1'b0) | 8'h01);
    chk("R4 sw ignored", start_pulse, 0);
    wr(kv(2'b11, 1'b0));
    chk("R6 write 1 no effect", {rd_data[1], stop_pulse}, 2);
    wr(kv(2'b11, 1'b0) & ~8'h02);
    chk("R6 stop pulse", stop_pulse, 1);
    chk("R6 busy cleared", rd_data[1], 0);
    chk("R6 flag not set", rd_data[2], 0);
    @(negedge clk);
    chk("R6 stop single", stop_pulse, 0);

    wr(kv(2'b00, 1'b1) | 8'h01);
    done_pulse();
    chk("R8 irq on", irq, 1);
    wr(kv(2'b00, 1'b1));
    chk("R7 write 1 keeps", rd_data[2], 1);
    wr(kv(2'b00, 1'b0));
    chk("R8 irq gated", irq, 0);
    wr(kv(2'b00, 1'b1) & ~8'h04);
    chk("R8 irq no flag", irq, 0);
    wr(kv(2'b00, 1'b1) | 8'h01);
    conv_done = 1; wr_en = 1; wr_data = kv(2'b00, 1'b1) & ~8'h04;
    @(negedge clk);
    conv_done = 0; wr_en = 0;
    chk("R7 set wins", rd_data[2], 1);
    chk("R8 irq after race", irq, 1);
    wr(kv(2'b00, 1'b0) & ~8'h04);

    pause_req = 1;
    @(negedge clk);
    pause_req = 0;
    chk("R9 pause set", rd_data[7], 1);
    wr(kv(2'b00, 1'b0));
    chk("R9 write 1 keeps", rd_data[7], 1);
    wr(kv(2'b00, 1'b0) & ~8'h80);
    chk("R9 cleared", rd_data[7], 0);
    pause_req = 1; wr_en = 1; wr_data = kv(2'b00, 1'b0) & ~8'h80;
    @(negedge clk);
    pause_req = 0; wr_en = 0;
    chk("R9 set wins", rd_data[7], 1);

    wr(kv(2'b00, 1'b0) | 8'h40);
    chk("R10 reserved reads 0", rd_data[6], 0);

    ext_trig = 1; wr_en = 1; wr_data = kv(2'b01, 1'b0);
    @(negedge clk);
    ext_trig = 0; wr_en = 0;
    chk("R11 old sel 00 blocks", start_pulse, 0);
    ext_trig = 1; wr_en = 1; wr_data = kv(2'b00, 1'b0);
    @(negedge clk);
    ext_trig = 0; wr_en = 0;
    chk("R11 old sel 01 starts", start_pulse, 1);
    chk("R11 sel updated", rd_data[5:4], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule